// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one complete frame on a single-wire, open-drain consumer-electronics control bus. It takes between 1 and 16 bytes from a packed 128-bit data word. A host sets up the payload, the byte count minus one, a set of timing counts and a clock divider. It then raises `start`.

The block first waits until the bus has been released for a programmed number of bit-clock ticks. It then drives a start bit, and after it each byte. Every byte goes out most significant bit first and is followed by an end-of-message bit and an acknowledge slot. All pulse and period lengths are tick counts from input ports. The bit clock is an enable that an internal divider derives from the fast system clock.

A missing acknowledge leads to one automatic retry. Arbitration loss on a released logic 1 bit stops the frame at once. At the end of every transmit the block raises `done` and the status flags, and pulses `irq` for one clock.

Top module: `cec_frame_tx`

## Requirements
- R1: The internal bit tick occurs once every `div_cnt`+1 clocks; a value of 4091 on a 163.68 MHz clock gives about 40 kHz. `cec_drive_low` changes only on a tick, so every pulse and period lasts exactly its tick count times (`div_cnt`+1) clocks.
- R2: Before the first pulse of every attempt, including a retry, the line must read high for at least `t_idle` consecutive ticks. A low reading restarts that count.
- R3: The start bit drives the line low for `t_start_low` ticks. The next bit begins `t_start_per` ticks after the start bit began.
- R4: Byte k of the frame is `tx_data[8k+7:8k]`, so byte 0 is the lowest byte lane, and each byte is sent bit 7 first. A 0 bit is low for `t_zero_low` ticks, a 1 bit is low for `t_one_low` ticks, and every bit period is `t_bit_per` ticks.
- R5: The frame carries exactly `len_m1`+1 bytes. Each byte is followed by an end-of-message bit, which is 1 only after the last byte, and then by an acknowledge slot sent as a 1. No other pulses are driven.
- R6: The line is sampled at tick `t_ack_smp` of each acknowledge slot. When the destination nibble `tx_data[3:0]` is not 15, a low sample accepts the byte. When the nibble is 15 (broadcast), a low sample rejects it.
- R7: A rejected acknowledge slot ends the attempt. The first rejection starts exactly one retry. `tx_good` is 1 when the first or the second attempt is accepted, and a second rejection ends the transmit with `tx_good` = 0.
- R8: At the end of a transmit, `busy` falls, `done` rises and `irq` is high for exactly one clock. `done`, `tx_good` and `arb_lost` then hold until the next accepted start, which clears them.
- R9: `start` is accepted only after it has been seen low while the block was idle. Holding `start` high after completion starts nothing.
- R10: If the line reads low at tick `t_ack_smp` of a data or end-of-message bit sent as 1, the block stops driving and ends the transmit with `arb_lost` = 1 and `tx_good` = 0, without a retry.
- R11: During and right after reset, `cec_drive_low`, `busy`, `done`, `tx_good`, `arb_lost` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cnt | input | 12 | Bit tick every div_cnt+1 clocks |
| t_idle | input | 8 | Released ticks needed before an attempt |
| t_start_low | input | 8 | Start bit low time in ticks |
| t_start_per | input | 8 | Start bit period in ticks |
| t_zero_low | input | 8 | Logic 0 low time in ticks |
| t_one_low | input | 8 | Logic 1 low time in ticks |
| t_bit_per | input | 8 | Data bit period in ticks |
| t_ack_smp | input | 8 | Sample tick within a bit |
| tx_data | input | 128 | Frame bytes, byte 0 in bits 7:0 |
| len_m1 | input | 4 | Byte count minus one |
| start | input | 1 | Transmit request level |
| cec_line | input | 1 | Sensed bus level (1 = released) |
| cec_drive_low | output | 1 | Pull the bus low when 1 |
| busy | output | 1 | Transmit in progress |
| done | output | 1 | Transmit finished (sticky) |
| tx_good | output | 1 | Frame was accepted |
| arb_lost | output | 1 | Arbitration was lost |
| irq | output | 1 | One-clock end-of-transmit pulse |

## Verification
The assertions rely on these input conditions:
- `div_cnt` stays constant and non-zero.
- The timing counts keep `t_one_low` < `t_ack_smp` < `t_zero_low` < `t_bit_per` and `t_start_low` < `t_start_per`.
- `tx_data` and `len_m1` do not change while `busy` is high.

The stimulus sets the divider and the timing counts only while the block is idle and holds them for whole frames. A bench-side responder pulls the line low only inside the acknowledge slots it decodes from the pulse queue. A separate jammer pulls it low only during a chosen 1 bit or before an attempt begins.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  localparam int MAX_BYTES = 16;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int SLOT_W    = 4;               // 8 data + EOM + ACK = 10 slots
  localparam logic [SLOT_W-1:0] SLOT_EOM = 4'd8;
  localparam logic [SLOT_W-1:0] SLOT_ACK = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} tx_state_e;

  // Value of one slot of byte byte_idx: data bits MSB first, then EOM, then ACK (sent as 1)
  function automatic logic frame_bit(input logic [DATA_W-1:0] data,
                                     input logic [IDX_W-1:0]  byte_idx,
                                     input logic [SLOT_W-1:0] slot,
                                     input logic [IDX_W-1:0]  last_idx);
    logic r;
    if (slot < SLOT_EOM)       r = data[{byte_idx, ~slot[2:0]}];
    else if (slot == SLOT_EOM) r = (byte_idx == last_idx);
    else                       r = 1'b1;
    return r;
  endfunction

  // Destination nibble 15 marks a broadcast frame
  function automatic logic is_broadcast(input logic [3:0] dest);
    return dest == 4'hF;
  endfunction
endpackage

// File: rtl/cec_tick_div.sv
module cec_tick_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cnt,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_cnt != '0 && $stable(div_cnt)) |=> !tick); // R1
endmodule

// File: rtl/cec_idle_mon.sv
module cec_idle_mon #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          line,
  input  logic [TW-1:0] t_idle,
  output logic          idle_ok
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  logic [TW-1:0] free_q;

  assign idle_ok = en && (free_q >= t_idle);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)    free_q <= '0;
    else if (tick) begin
      if (!line)          free_q <= '0;
      else if (free_q != CNT_MAX) free_q <= free_q + 1'b1;
    end
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(tick) && !$past(line)) |-> !idle_ok || t_idle == '0); // R2
endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int TW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cnt,
  input  logic [TW-1:0]     t_idle,
  input  logic [TW-1:0]     t_start_low,
  input  logic [TW-1:0]     t_start_per,
  input  logic [TW-1:0]     t_zero_low,
  input  logic [TW-1:0]     t_one_low,
  input  logic [TW-1:0]     t_bit_per,
  input  logic [TW-1:0]     t_ack_smp,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [IDX_W-1:0]  len_m1,
  input  logic              start,
  input  logic              cec_line,
  output logic              cec_drive_low,
  output logic              busy,
  output logic              done,
  output logic              tx_good,
  output logic              arb_lost,
  output logic              irq
);
  tx_state_e         state_q;
  logic [TW-1:0]     ph_q;
  logic              in_start_q;
  logic [IDX_W-1:0]  byte_q;
  logic [SLOT_W-1:0] slot_q;
  logic              retry_q;
  logic              nack_q;
  logic              armed_q;
  logic              drive_q, done_q, good_q, arb_q, irq_q;

  // Named internal events
  logic              tick, idle_ok;
  logic              cur_bit, is_ack, last_byte;
  logic [TW-1:0]     low_len, per_len;
  logic              accept, send_tick, sample_pt, ack_sample, arb_hit, bit_end;

  cec_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_cnt(div_cnt), .tick(tick));

  cec_idle_mon #(.TW(TW)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_WAIT), .tick(tick),
    .line(cec_line), .t_idle(t_idle), .idle_ok(idle_ok));

  assign cur_bit    = in_start_q ? 1'b0 : frame_bit(tx_data, byte_q, slot_q, len_m1);
  assign is_ack     = !in_start_q && (slot_q == SLOT_ACK);
  assign last_byte  = (byte_q == len_m1);
  assign low_len    = in_start_q ? t_start_low : (cur_bit ? t_one_low : t_zero_low);
  assign per_len    = in_start_q ? t_start_per : t_bit_per;
  assign accept     = (state_q == ST_IDLE) && start && armed_q;
  assign send_tick  = (state_q == ST_SEND) && tick;
  assign sample_pt  = send_tick && !in_start_q && (ph_q == t_ack_smp);
  assign ack_sample = sample_pt && is_ack;
  assign arb_hit    = sample_pt && !is_ack && cur_bit && !cec_line;
  assign bit_end    = send_tick && (ph_q == per_len - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  ph_q <= '0;   in_start_q <= 1'b0;
      byte_q <= '0;        slot_q <= '0; retry_q <= 1'b0;
      nack_q <= 1'b0;      armed_q <= 1'b0;
      drive_q <= 1'b0;     done_q <= 1'b0; good_q <= 1'b0;
      arb_q <= 1'b0;       irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (state_q != ST_IDLE) armed_q <= 1'b0;
      else if (!start)        armed_q <= 1'b1;
      else if (accept)        armed_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WAIT;
          retry_q <= 1'b0;
          done_q  <= 1'b0; good_q <= 1'b0; arb_q <= 1'b0;
        end
        ST_WAIT: if (tick && idle_ok && cec_line) begin
          state_q    <= ST_SEND;
          ph_q       <= '0;
          in_start_q <= 1'b1;
          byte_q     <= '0;
          slot_q     <= '0;
          nack_q     <= 1'b0;
        end
        ST_SEND: if (tick) begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == '0)      drive_q <= 1'b1;
          if (ph_q == low_len) drive_q <= 1'b0;
          if (ack_sample)
            nack_q <= is_broadcast(tx_data[3:0]) ? !cec_line : cec_line;
          if (arb_hit) begin
            drive_q <= 1'b0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1; arb_q <= 1'b1; irq_q <= 1'b1;
          end else if (bit_end) begin
            ph_q <= '0;
            if (in_start_q) begin
              in_start_q <= 1'b0;
              slot_q     <= '0;
            end else if (!is_ack) begin
              slot_q <= slot_q + 1'b1;
            end else if (nack_q) begin
              if (retry_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1; irq_q <= 1'b1;
              end else begin
                retry_q <= 1'b1;
                state_q <= ST_WAIT;
              end
            end else if (last_byte) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1; good_q <= 1'b1; irq_q <= 1'b1;
            end else begin
              byte_q <= byte_q + 1'b1;
              slot_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cec_drive_low = drive_q;
  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign tx_good       = good_q;
  assign arb_lost      = arb_q;
  assign irq           = irq_q;

  AST_DRIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cec_drive_low != $past(cec_drive_low)) |-> $past(tick)); // R1
  AST_DRIVE_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SEND) |-> !cec_drive_low); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !busy && $past(busy))); // R8
  AST_GOOD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_good |-> done); // R7
  AST_ARB_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!tx_good && !cec_drive_low)); // R10
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start) && !busy) |=> !busy); // R9
  AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_q && state_q == ST_SEND && bit_end && is_ack && nack_q) |=> !busy); // R7
endmodule

// File: tb/cec_frame_tx_tb_top.sv
module cec_frame_tx_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [11:0]  div_cnt = 12'd1;
  logic [7:0]   t_idle = 8'd5, t_start_low = 8'd8, t_start_per = 8'd11;
  logic [7:0]   t_zero_low = 8'd5, t_one_low = 8'd2, t_bit_per = 8'd8, t_ack_smp = 8'd4;
  logic [127:0] tx_data = '0;
  logic [3:0]   len_m1 = '0;
  logic         start = 1'b0;
  logic         fol_low = 1'b0, jam_low = 1'b0, hold_low = 1'b0;
  logic         drv, busy, done, tx_good, arb_lost, irq;
  wire          line = !(drv | fol_low | jam_low | hold_low);

  cec_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .div_cnt(div_cnt), .t_idle(t_idle),
    .t_start_low(t_start_low), .t_start_per(t_start_per), .t_zero_low(t_zero_low),
    .t_one_low(t_one_low), .t_bit_per(t_bit_per), .t_ack_smp(t_ack_smp),
    .tx_data(tx_data), .len_m1(len_m1), .start(start), .cec_line(line),
    .cec_drive_low(drv), .busy(busy), .done(done), .tx_good(tx_good),
    .arb_lost(arb_lost), .irq(irq));

  int checks = 0, fails = 0;
  int cyc = 0;
  int tick_cyc = 2;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  // Reference model: queue of expected pulses (low ticks, period ticks, kind, attempt)
  int q_low[$], q_per[$], q_kind[$], q_att[$];
  bit ack_plan[2];
  int jam_at = 0, pulse_cnt = 0, first_rise = -1, first_low = -1;
  int last_rise = 0, prev_per = 0, prev_kind = 0, cur_low = 0, cur_kind = 0;
  int fol_cnt = 0, jam_cnt = 0, irq_cnt = 0;
  bit have_prev = 0;
  logic prev_drv = 1'b0;

  always @(negedge clk) begin
    if (fol_cnt > 0) begin fol_cnt--; if (fol_cnt == 0) fol_low = 1'b0; end
    if (jam_cnt > 0) begin jam_cnt--; if (jam_cnt == 0) jam_low = 1'b0; end
    if (rst_n && irq) irq_cnt++;
    if (rst_n && drv && !prev_drv) begin
      if (q_low.size() == 0) chk(0, "R5", "unexpected pulse", cyc, -1);
      else begin
        int this_per, this_att;
        cur_low = q_low.pop_front(); cur_kind = q_kind.pop_front();
        this_att = q_att.pop_front(); this_per = q_per.pop_front();
        if (cur_kind != 0 && have_prev)
          chk(cyc - last_rise == prev_per * tick_cyc, prev_kind == 0 ? "R3" : "R4",
              "period", cyc - last_rise, prev_per * tick_cyc);
        prev_per = this_per; prev_kind = cur_kind; have_prev = 1; last_rise = cyc;
        pulse_cnt++;
        if (pulse_cnt == 1) first_rise = cyc;
        if (cur_kind == 2 && ack_plan[this_att]) begin fol_low = 1'b1; fol_cnt = t_zero_low * tick_cyc; end
        if (jam_at == pulse_cnt) begin jam_low = 1'b1; jam_cnt = 6 * tick_cyc; end
      end
    end
    if (rst_n && !drv && prev_drv) begin
      if (pulse_cnt == 1) first_low = cyc - last_rise;
      chk(cyc - last_rise == cur_low * tick_cyc, cur_kind == 0 ? "R3" : "R4",
          "low time", cyc - last_rise, cur_low * tick_cyc);
    end
    prev_drv = drv;
  end

  task automatic push(input int lo, input int per, input int kind, input int att,
                      inout int n, input int maxp);
    if (n < maxp) begin
      q_low.push_back(lo); q_per.push_back(per); q_kind.push_back(kind); q_att.push_back(att);
    end
    n++;
  endtask

  task automatic build(input logic [127:0] d, input int lm1, input int natt, input int maxp);
    int n = 0;
    for (int a = 0; a < natt; a++) begin
      push(t_start_low, t_start_per, 0, a, n, maxp);
      for (int b = 0; b <= lm1; b++) begin
        for (int p = 0; p < 8; p++)
          push(d[b*8 + 7 - p] ? t_one_low : t_zero_low, t_bit_per, 1, a, n, maxp);
        push(b == lm1 ? t_one_low : t_zero_low, t_bit_per, 1, a, n, maxp);
        push(t_one_low, t_bit_per, 2, a, n, maxp);
      end
    end
  endtask

  task automatic run_frame(input logic [127:0] d, input int lm1, input bit a0, input bit a1,
                           input int natt, input bit eg, input bit ea, input int jam_p,
                           input int maxp, input int hold, input string rq);
    int n, ref_c;
    start = 1'b0;
    repeat (3) @(negedge clk);
    q_low.delete(); q_per.delete(); q_kind.delete(); q_att.delete();
    ack_plan[0] = a0; ack_plan[1] = a1; jam_at = jam_p;
    pulse_cnt = 0; have_prev = 0; irq_cnt = 0; first_rise = -1;
    build(d, lm1, natt, maxp);
    tx_data = d; len_m1 = 4'(lm1);
    if (hold > 0) hold_low = 1'b1;
    start = 1'b1; ref_c = cyc;
    repeat (2) @(negedge clk);
    chk(busy && !done && !tx_good, "R8", "accept clears status", {busy, done, tx_good}, 3'b100);
    if (hold > 0) begin repeat (hold) @(negedge clk); hold_low = 1'b0; ref_c = cyc; end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, "R8", "transmit finished", done, 1);
    repeat (4) @(negedge clk);
    chk(first_rise - ref_c >= t_idle * tick_cyc && first_rise - ref_c <= (t_idle + 3) * tick_cyc,
        "R2", "idle wait before first pulse", first_rise - ref_c, t_idle * tick_cyc);
    chk(tx_good == eg, rq, "tx_good", tx_good, eg);
    chk(arb_lost == ea, "R10", "arb_lost", arb_lost, ea);
    chk(irq_cnt == 1, "R8", "irq pulses", irq_cnt, 1);
    chk(!busy, "R8", "busy low at end", busy, 0);
    chk(q_low.size() == 0, "R5", "pulses missing", q_low.size(), 0);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({drv, busy, done, tx_good, arb_lost, irq} == 6'b0, "R11", "outputs in reset",
        {drv, busy, done, tx_good, arb_lost, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({drv, busy, done, tx_good, arb_lost, irq} == 6'b0, "R11", "outputs after reset",
        {drv, busy, done, tx_good, arb_lost, irq}, 0);

    // R4 R5 R6: single byte, directed, acknowledged
    run_frame(128'h40, 0, 1, 1, 1, 1, 0, 0, 999, 0, "R6");
    repeat (50) @(negedge clk);
    chk(done && tx_good, "R8", "status holds while idle", {done, tx_good}, 3);

    // R9: start held high after completion starts nothing
    pulse_cnt = 0;
    repeat (200) @(negedge clk);
    chk(!busy && pulse_cnt == 0, "R9", "no transmit without re-arm", {busy, pulse_cnt}, 0);

    // R4 R5: three bytes, byte lanes ascending
    run_frame(128'hA58F04, 2, 1, 1, 1, 1, 0, 0, 999, 0, "R5");
    // R5 boundary: sixteen bytes
    run_frame(128'hF0E1D2C3B4A5968778695A4B3C2D1E01, 15, 1, 1, 1, 1, 0, 0, 999, 0, "R5");
    // R7: no acknowledge on both attempts
    run_frame(128'h35, 0, 0, 0, 2, 0, 0, 0, 999, 0, "R7");
    // R7: rejected then accepted on retry
    run_frame(128'h35, 0, 0, 1, 2, 1, 0, 0, 999, 0, "R7");
    // R6: broadcast, silent line means accepted
    run_frame(128'h4F, 0, 0, 0, 1, 1, 0, 0, 999, 0, "R6");
    // R6 R7: broadcast rejected by a low sample, then accepted
    run_frame(128'h4F, 0, 1, 0, 2, 1, 0, 0, 999, 0, "R6");
    // R10: another initiator drives the third pulse (bit 6 = 1) low
    run_frame(128'h40, 0, 1, 1, 1, 0, 1, 3, 3, 0, "R10");
    // R2: line held low after start delays the first pulse
    run_frame(128'h5A, 0, 1, 1, 1, 1, 0, 0, 999, 40, "R2");

    // R1: slower divider, all times scale with div_cnt+1
    start = 1'b0;
    repeat (4) @(negedge clk);
    div_cnt = 12'd3; tick_cyc = 4;
    run_frame(128'hC3_12, 1, 1, 1, 1, 1, 0, 0, 999, 0, "R6");
    chk(first_low == t_start_low * 4, "R1", "start low scaled by divider", first_low, t_start_low * 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule